// File: doc/BRIEF.md
# SPI Register Port Front End with Sticky Mode Select

This block sits at the pin side of a register control port. After reset the port serves the two-wire I2C bus, and the block only reports that mode. A host moves the port to four-wire SPI by pulsing the active-low latch line low three times. Those three transactions are dummies: their contents are dropped. From the fourth latch-framed transaction on, the block decodes SPI traffic. It issues register or memory write strobes and fetches read data, which it shifts back out to the host. Only a reset brings the port back to I2C.

Every SPI transaction starts with three bytes. The first byte holds a chip address, which is not compared, and a read/write flag. The second and third bytes give a 16-bit target address, high byte first. Data bytes follow. The number of bytes per address depends on the address. The low memory window holds 28-bit parameter words, sent as four bytes with the top four bits unused. Every other address is a single-byte register. A burst continues to the following addresses, one complete word per address.

All pin inputs are brought into the system clock domain through synchronizers. The SPI clock is then edge-detected in that domain, so it must run well below the system clock.

Top module: `ctlport_spi_front`

## Requirements
- R1: After reset `i2cMode` is 1, `wrEn` and `rdReq` are 0 and `spiMiso` is 0.
- R2: The first three low pulses of `spiLatchN` after reset cause no write strobe and no read request, whatever is shifted during them. `i2cMode` falls once the third pulse has ended.
- R3: From the fourth latch-low transaction on, writes and reads take effect.
- R4: Once `i2cMode` is 0 it stays 0 through any further latch activity until `rst_n` is asserted.
- R5: Bits are sampled on the rising edge of `spiClk`, most significant bit first. Byte 0 carries a chip address in bits 7:1, which is ignored, and the direction in bit 0 (1 = read, 0 = write). Byte 1 is address bits 15:8 and byte 2 is address bits 7:0.
- R6: For an address at or below `PARAM_TOP` (default 0x03FF), a word is four data bytes. The upper nibble of the first byte is discarded, its lower nibble gives bits 27:24, and the next three bytes give bits 23:0. One `wrEn` pulse then carries the 28-bit word.
- R7: For an address above `PARAM_TOP`, each data byte is a complete word. The `wrEn` pulse carries the byte on `wrData[7:0]` with the upper bits zero.
- R8: In a burst, each completed word goes to the address one above the previous word's address. The word size is chosen again for every address, so a burst that steps from 0x03FF to 0x0400 switches from four-byte to one-byte words. Each `wrEn` is a one-cycle pulse.
- R9: In a read, `rdReq` pulses for one cycle with `rdAddr` equal to the target address, and `rdData` is taken in that cycle. The word is then driven on `spiMiso` MSB first, changing on falling edges of `spiClk`. A parameter word is sent as 32 bits with four leading zeros. A register is sent as 8 bits. After each word the next address is requested.
- R10: A rising edge on `spiLatchN` ends the transaction. A partly received byte or word is discarded without a write strobe, and the next transaction starts framing afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, the only way back to I2C mode |
| spiClk | input | 1 | SPI serial clock from the host |
| spiLatchN | input | 1 | Active-low SPI latch (chip select) |
| spiMosi | input | 1 | Serial data from the host |
| spiMiso | output | 1 | Serial read data to the host |
| i2cMode | output | 1 | 1 while the port is still in I2C mode |
| wrEn | output | 1 | One-cycle write strobe |
| wrAddr | output | 16 | Address of the write |
| wrData | output | WORD_W | Write data (28-bit word or byte in bits 7:0) |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | 16 | Address being read |
| rdData | input | WORD_W | Read data, valid in the cycle `rdReq` is high |

## Verification
The bench first sends complete write frames inside the three dummy pulses. A design that counts one pulse too few, or that decodes before switching, would produce a write there. It then runs a parameter burst that crosses 0x03FF into register space. A design that fixes the word size at the start of a transaction would swallow the byte at 0x0400 into a half-built word. Transactions cut off after two parameter bytes, and again in the middle of a byte, must leave no write behind. A later clean write must land at the right address, which catches a bit or byte counter that survives the latch edge. Reads are checked bit by bit on the serial output against the bench's own memory model. This exposes an off-by-one shift at the word start and a burst that fails to prefetch the next address.

// File: rtl/ctlport_pkg.sv
`timescale 1ns/1ps
package ctlport_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA
  } phase_e;

  // Strobes from the control sequencer to the datapath, valid for one clk.
  typedef struct packed {
    logic shiftIn;     // take one bit from the synchronized MOSI
    logic takeHi;      // completed byte is address high byte
    logic takeLo;      // completed byte is address low byte
    logic takeData;    // completed byte is a write data byte
    logic issueWrite;  // completed byte closes a write word
    logic incAddr;     // step to the next address after a word
    logic readLoad;    // fetch read data into the transmit register
    logic txShift;     // advance the transmit register by one bit
    logic drop;        // transaction ended, clear transmit state
  } dpCmd_t;

endpackage

// File: rtl/ctlport_sync.sv
`timescale 1ns/1ps
module ctlport_sync #(
  parameter int             WIDTH     = 1,
  parameter int             STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= CHAIN_W'({chain, din});
  end

  assign dout = chain[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/ctlport_ctl.sv
`timescale 1ns/1ps
module ctlport_ctl
  import ctlport_pkg::*;
#(
  parameter int MODE_PULSES = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclkS,
  input  logic   latchS,
  input  logic   mosiS,
  input  logic   wordIsParam,
  output dpCmd_t cmd,
  output logic   spiMode
);

  localparam int PCNT_W = $clog2(MODE_PULSES + 1);

  logic              sclkQ, latchQ;
  logic              sRise, sFall, lRise, lFall;
  logic [PCNT_W-1:0] pulseCnt;
  logic              active;
  phase_e            phase;
  logic [2:0]        bitCnt;
  logic [1:0]        wordByte;
  logic [1:0]        lastIdx;
  logic              isRead;
  logic              readPend;
  logic              fresh;
  logic              go, byteEnd, wordEnd;

  assign sRise = sclkS & ~sclkQ;
  assign sFall = ~sclkS & sclkQ;
  assign lRise = latchS & ~latchQ;
  assign lFall = ~latchS & latchQ;

  assign lastIdx = wordIsParam ? 2'd3 : 2'd0;
  assign go      = active & ~lRise;
  assign byteEnd = sRise & (bitCnt == 3'd7);
  assign wordEnd = byteEnd & (phase == PH_DATA) & (wordByte == lastIdx);

  always_comb begin
    cmd            = '0;
    cmd.shiftIn    = go & sRise;
    cmd.takeHi     = go & byteEnd & (phase == PH_ADDR_HI);
    cmd.takeLo     = go & byteEnd & (phase == PH_ADDR_LO);
    cmd.takeData   = go & byteEnd & (phase == PH_DATA) & ~isRead;
    cmd.issueWrite = go & wordEnd & ~isRead;
    cmd.incAddr    = go & wordEnd;
    cmd.readLoad   = readPend;
    cmd.txShift    = go & sFall & isRead & (phase == PH_DATA) & ~fresh & ~readPend;
    cmd.drop       = lRise;
  end

  // Mode latch: counts completed latch-low pulses while in I2C mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spiMode  <= 1'b0;
      pulseCnt <= '0;
    end else if (!spiMode && lRise) begin
      pulseCnt <= pulseCnt + 1'b1;
      if (pulseCnt == PCNT_W'(MODE_PULSES - 1)) spiMode <= 1'b1;
    end
  end

  // Transaction framing and byte sequencing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkQ    <= 1'b0;
      latchQ   <= 1'b1;
      active   <= 1'b0;
      phase    <= PH_CMD;
      bitCnt   <= '0;
      wordByte <= '0;
      isRead   <= 1'b0;
      readPend <= 1'b0;
      fresh    <= 1'b0;
    end else begin
      sclkQ    <= sclkS;
      latchQ   <= latchS;
      readPend <= 1'b0;
      if (lRise) begin
        active   <= 1'b0;
        phase    <= PH_CMD;
        bitCnt   <= '0;
        wordByte <= '0;
        isRead   <= 1'b0;
        fresh    <= 1'b0;
      end else if (lFall) begin
        active   <= spiMode;
        phase    <= PH_CMD;
        bitCnt   <= '0;
        wordByte <= '0;
        isRead   <= 1'b0;
        fresh    <= 1'b0;
      end else if (active) begin
        if (readPend) begin
          fresh <= 1'b1;
        end else if (sFall && fresh) begin
          fresh <= 1'b0;
        end
        if (sRise) begin
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            unique case (phase)
              PH_CMD: begin
                isRead <= mosiS;
                phase  <= PH_ADDR_HI;
              end
              PH_ADDR_HI: phase <= PH_ADDR_LO;
              PH_ADDR_LO: begin
                phase    <= PH_DATA;
                wordByte <= '0;
                readPend <= isRead;
              end
              PH_DATA: begin
                if (wordByte == lastIdx) begin
                  wordByte <= '0;
                  readPend <= isRead;
                end else begin
                  wordByte <= wordByte + 2'd1;
                end
              end
              default: phase <= PH_CMD;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/ctlport_dp.sv
`timescale 1ns/1ps
module ctlport_dp
  import ctlport_pkg::*;
#(
  parameter int                WORD_W    = 28,
  parameter logic [ADDR_W-1:0] PARAM_TOP = 16'h03FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCmd_t            cmd,
  input  logic              mosiS,
  input  logic [WORD_W-1:0] rdData,
  output logic              wordIsParam,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              miso
);

  localparam int WORD_BYTES = (WORD_W + BYTE_W - 1) / BYTE_W;
  localparam int TX_W       = WORD_BYTES * BYTE_W;

  logic [BYTE_W-1:0] rxByte;
  logic [BYTE_W-1:0] byteNow;
  logic [TX_W-1:0]   wordAcc;
  logic [TX_W-1:0]   wordNext;
  logic [TX_W-1:0]   txReg;

  assign byteNow     = {rxByte[BYTE_W-2:0], mosiS};
  assign wordNext    = {wordAcc[TX_W-BYTE_W-1:0], byteNow};
  assign wordIsParam = (curAddr <= PARAM_TOP);
  assign miso        = txReg[TX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxByte  <= '0;
      wordAcc <= '0;
      curAddr <= '0;
    end else begin
      if (cmd.shiftIn)  rxByte  <= byteNow;
      if (cmd.takeData) wordAcc <= wordNext;
      if (cmd.takeHi)       curAddr[ADDR_W-1 -: BYTE_W] <= byteNow;
      else if (cmd.takeLo)  curAddr[BYTE_W-1:0]         <= byteNow;
      else if (cmd.incAddr) curAddr <= curAddr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= cmd.issueWrite;
      if (cmd.issueWrite) begin
        wrAddr <= curAddr;
        wrData <= wordIsParam ? wordNext[WORD_W-1:0] : WORD_W'(byteNow);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReg <= '0;
    end else if (cmd.drop) begin
      txReg <= '0;
    end else if (cmd.readLoad) begin
      txReg <= wordIsParam ? TX_W'(rdData)
                           : {rdData[BYTE_W-1:0], {(TX_W-BYTE_W){1'b0}}};
    end else if (cmd.txShift) begin
      txReg <= {txReg[TX_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/ctlport_spi_front.sv
`timescale 1ns/1ps
module ctlport_spi_front
  import ctlport_pkg::*;
#(
  parameter int                WORD_W      = 28,
  parameter logic [ADDR_W-1:0] PARAM_TOP   = 16'h03FF,
  parameter int                MODE_PULSES = 3,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spiClk,
  input  logic              spiLatchN,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic              i2cMode,
  output logic              wrEn,
  output logic [15:0]       wrAddr,
  output logic [WORD_W-1:0] wrData,
  output logic              rdReq,
  output logic [15:0]       rdAddr,
  input  logic [WORD_W-1:0] rdData
);

  logic [2:0] pinsS;
  dpCmd_t     cmd;
  logic       spiMode;
  logic       wordIsParam;

  // Order {clock, latch, data}; the latch idles high.
  ctlport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spiClk, spiLatchN, spiMosi}),
    .dout (pinsS)
  );

  ctlport_ctl #(.MODE_PULSES(MODE_PULSES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclkS      (pinsS[2]),
    .latchS     (pinsS[1]),
    .mosiS      (pinsS[0]),
    .wordIsParam(wordIsParam),
    .cmd        (cmd),
    .spiMode    (spiMode)
  );

  ctlport_dp #(.WORD_W(WORD_W), .PARAM_TOP(PARAM_TOP)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .mosiS      (pinsS[0]),
    .rdData     (rdData),
    .wordIsParam(wordIsParam),
    .curAddr    (rdAddr),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .miso       (spiMiso)
  );

  assign i2cMode = ~spiMode;
  assign rdReq   = cmd.readLoad;

endmodule

// File: rtl/ctlport_spi_front_chk.sv
`timescale 1ns/1ps
module ctlport_spi_front_chk #(
  parameter int          WORD_W    = 28,
  parameter logic [15:0] PARAM_TOP = 16'h03FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spiLatchN,
  input logic              i2cMode,
  input logic              wrEn,
  input logic [15:0]       wrAddr,
  input logic [WORD_W-1:0] wrData,
  input logic              rdReq
);

  logic        havePrev;
  logic [15:0] prevAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      havePrev <= 1'b0;
      prevAddr <= '0;
    end else if (spiLatchN) begin
      havePrev <= 1'b0;
    end else if (wrEn) begin
      havePrev <= 1'b1;
      prevAddr <= wrAddr;
    end
  end

  p_quiet_in_i2c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    i2cMode |-> (!wrEn && !rdReq));

  p_mode_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !i2cMode |=> !i2cMode);

  p_reg_byte_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && (wrAddr > PARAM_TOP)) |-> (wrData[WORD_W-1:8] == '0));

  p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && havePrev) |-> (wrAddr == prevAddr + 16'd1));

  p_write_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> !wrEn);

  p_read_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdReq |=> !rdReq);

endmodule

bind ctlport_spi_front ctlport_spi_front_chk #(.WORD_W(WORD_W), .PARAM_TOP(PARAM_TOP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .spiLatchN(spiLatchN),
  .i2cMode  (i2cMode),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .rdReq    (rdReq)
);

// File: tb/sim_ctlport_spi_front.sv
`timescale 1ns/1ps
module sim_ctlport_spi_front;

  localparam int HALF    = 40;
  localparam int WDOG_NS = 900000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        latchN = 1'b1;
  logic        mosi = 1'b0;
  logic        miso, i2cMode, wrEn, rdReq;
  logic [15:0] wrAddr, rdAddr;
  logic [27:0] wrData, rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [15:0] wrAddrLog [64];
  logic [27:0] wrDataLog [64];
  logic [15:0] rdAddrLog [64];
  int wrCount = 0;
  int rdCount = 0;

  always #2.5 clk = ~clk;

  function automatic logic [27:0] memModel(input logic [15:0] a);
    return {a[11:0], a} ^ 28'h5A3C96E;
  endfunction

  assign rdData = memModel(rdAddr);

  ctlport_spi_front u0 (
    .clk(clk), .rst_n(rst_n), .spiClk(sclk), .spiLatchN(latchN), .spiMosi(mosi),
    .spiMiso(miso), .i2cMode(i2cMode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData)
  );

  always @(negedge clk) begin
    if (wrEn && wrCount < 64) begin
      wrAddrLog[wrCount] = wrAddr;
      wrDataLog[wrCount] = wrData;
      wrCount++;
    end
    if (rdReq && rdCount < 64) begin
      rdAddrLog[rdCount] = rdAddr;
      rdCount++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spiByte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      #HALF;
      r[i] = miso;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
  endtask

  task automatic latchLow();
    latchN = 1'b0;
    #HALF;
  endtask

  task automatic latchHigh();
    #HALF;
    latchN = 1'b1;
    #(HALF * 6);
  endtask

  task automatic xfer(input logic [7:0] cmdB, input logic [15:0] addr, input int n,
                      input logic [7:0] d [8], output logic [7:0] rx [8]);
    logic [7:0] junk;
    latchLow();
    spiByte(cmdB, junk);
    spiByte(addr[15:8], junk);
    spiByte(addr[7:0], junk);
    for (int k = 0; k < n; k++) spiByte(d[k], rx[k]);
    latchHigh();
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    #20;
    rst_n = 1'b1;
    #20;
  endtask

  task automatic t_reset();
    #3;
    chk("R1 i2cMode", {31'd0, i2cMode}, 32'd1);
    chk("R1 wrEn", {31'd0, wrEn}, 32'd0);
    chk("R1 rdReq", {31'd0, rdReq}, 32'd0);
    chk("R1 miso", {31'd0, miso}, 32'd0);
  endtask

  task automatic t_dummies();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    d = '{8'h55, 8'h66, 8'h77, 8'h88, 8'h0, 8'h0, 8'h0, 8'h0};
    for (int k = 0; k < 3; k++) begin
      xfer(8'hE0, 16'h4000, 1, d, rx);
      chk("R2 no write in dummy", wrCount, 0);
      chk("R2 no read in dummy", rdCount, 0);
      chk("R2 mode after pulse", {31'd0, i2cMode}, (k < 2) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic t_regWrite();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int base = wrCount;
    d = '{8'hA7, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'h02, 16'h4010, 1, d, rx);
    chk("R3 fourth transaction writes", wrCount - base, 1);
    chk("R5 R7 reg addr", {16'd0, wrAddrLog[base]}, 32'h4010);
    chk("R7 reg data", {4'd0, wrDataLog[base]}, 32'h00000A7);
  endtask

  task automatic t_regBurst();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int base = wrCount;
    d = '{8'h11, 8'hF2, 8'h33, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h4020, 3, d, rx);
    chk("R8 burst count", wrCount - base, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R8 burst addr", {16'd0, wrAddrLog[base + k]}, 32'h4020 + k);
      chk("R7 burst data", {4'd0, wrDataLog[base + k]}, {24'd0, d[k]});
    end
  endtask

  task automatic t_paramWrite();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int base = wrCount;
    d = '{8'hF1, 8'h23, 8'h45, 8'h67, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h0010, 4, d, rx);
    chk("R6 param count", wrCount - base, 1);
    chk("R6 param addr", {16'd0, wrAddrLog[base]}, 32'h0010);
    chk("R6 param data", {4'd0, wrDataLog[base]}, 32'h1234567);
  endtask

  task automatic t_paramCross();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int base = wrCount;
    d = '{8'h0A, 8'hBC, 8'hDE, 8'hF0, 8'h99, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h03FF, 5, d, rx);
    chk("R8 cross count", wrCount - base, 2);
    chk("R8 cross addr0", {16'd0, wrAddrLog[base]}, 32'h03FF);
    chk("R6 cross data0", {4'd0, wrDataLog[base]}, 32'hABCDEF0);
    chk("R8 cross addr1", {16'd0, wrAddrLog[base + 1]}, 32'h0400);
    chk("R7 cross data1", {4'd0, wrDataLog[base + 1]}, 32'h99);
  endtask

  task automatic t_partial();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    logic [7:0] junk;
    int base = wrCount;
    d = '{8'h12, 8'h34, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h0020, 2, d, rx);
    chk("R10 partial word dropped", wrCount - base, 0);
    latchLow();
    spiByte(8'hE0, junk);
    spiByte(8'h40, junk);
    spiByte(8'h30, junk);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1;
      #HALF;
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    latchHigh();
    chk("R10 partial byte dropped", wrCount - base, 0);
    d = '{8'h3C, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h4030, 1, d, rx);
    chk("R10 clean framing after cut", wrCount - base, 1);
    chk("R10 clean addr", {16'd0, wrAddrLog[base]}, 32'h4030);
    chk("R10 clean data", {4'd0, wrDataLog[base]}, 32'h3C);
  endtask

  task automatic t_regRead();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int rbase = rdCount;
    int wbase = wrCount;
    logic [27:0] m = memModel(16'h4005);
    d = '{default: 8'h0};
    xfer(8'hE1, 16'h4005, 1, d, rx);
    chk("R9 read requested", {31'd0, (rdCount > rbase)}, 32'd1);
    chk("R9 read addr", {16'd0, rdAddrLog[rbase]}, 32'h4005);
    chk("R9 reg read data", {24'd0, rx[0]}, {24'd0, m[7:0]});
    chk("R9 no write on read", wrCount - wbase, 0);
  endtask

  task automatic t_paramReadBurst();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int rbase = rdCount;
    logic [27:0] m0 = memModel(16'h0005);
    logic [27:0] m1 = memModel(16'h0006);
    d = '{default: 8'h0};
    xfer(8'hE1, 16'h0005, 8, d, rx);
    chk("R9 param read word0", {rx[0], rx[1], rx[2], rx[3]}, {4'd0, m0});
    chk("R9 param read word1", {rx[4], rx[5], rx[6], rx[7]}, {4'd0, m1});
    chk("R9 burst second addr", {16'd0, rdAddrLog[rbase + 1]}, 32'h0006);
  endtask

  task automatic t_sticky();
    logic [7:0] d [8];
    logic [7:0] rx [8];
    int base;
    for (int k = 0; k < 3; k++) begin
      latchLow();
      latchHigh();
    end
    chk("R4 stays in SPI mode", {31'd0, i2cMode}, 32'd0);
    base = wrCount;
    d = '{8'h5E, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    xfer(8'hE0, 16'h4040, 1, d, rx);
    chk("R4 write still active", wrCount - base, 1);
    doReset();
    chk("R4 reset returns to I2C", {31'd0, i2cMode}, 32'd1);
    base = wrCount;
    xfer(8'hE0, 16'h4041, 1, d, rx);
    chk("R2 write after reset is dummy", wrCount - base, 0);
  endtask

  initial begin
    #(WDOG_NS);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset();
    t_reset();
    t_dummies();
    t_regWrite();
    t_regBurst();
    t_paramWrite();
    t_paramCross();
    t_partial();
    t_regRead();
    t_paramReadBurst();
    t_sticky();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule